// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial bus slave that holds a small bank of configuration bytes for clock-control logic. It runs on a fast system clock and oversamples SCL and SDA. It does not use SCL as a clock. Every stored byte is driven in parallel on `cfgBytes`. Three bits of byte 0 are also decoded onto their own pins: output tristate, spread-spectrum enable, and the choice between pin-based and register-based frequency selection.

The framing is fixed. In a write, the master sends a command code and a byte count. The slave acknowledges both and throws them away. The data bytes that follow fill the bank from byte 0 upward. In a read, the slave first returns a byte count and then the stored bytes in order. No register index can be addressed, so every access starts at byte 0. The master may end a write with STOP after any whole byte. Bytes not reached keep their old values.

SDA is open drain. `sdaOe` high means the slave pulls the line low.

Top module: `i2cBlockCfg`

## Requirements
- R1: After reset, byte 0 reads 0x00 and bytes 1 to 6 hold the `RESET_VALUE` parameter (byte i at bits 8i+7..8i). The default is 0x5AC3817E24FF00, so bytes 6 down to 1 are 5A, C3, 81, 7E, 24, FF.
- R2: The address byte 0xD2 (write) or 0xD3 (read) is acknowledged by holding SDA low during the ninth clock. Any other address gets no acknowledge, and the slave neither acknowledges nor stores anything until the next START.
- R3: In a write, the two bytes after the address (command code, then byte count) are each acknowledged, and neither changes any stored byte.
- R4: Data bytes of a write, received MSB first, are each acknowledged and stored in order into byte 0, byte 1, and so on up to byte 6.
- R5: A STOP after any whole data byte keeps the bytes already received, and later bytes keep their previous values.
- R6: Data bytes past byte 6 are acknowledged and discarded.
- R7: After a read address, the slave sends the count value 7 and then bytes 0 to 6, MSB first, moving on each time the master acknowledges.
- R8: A master NACK during a read ends the transfer. The slave leaves SDA released for every following clock until the next START. A STOP also releases SDA.
- R9: `outHiZ`, `spreadEn` and `freqFromReg` follow bits 0, 1 and 3 of byte 0.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 = pull SDA low |
| cfgBytes | output | NUM_BYTES*8 | All stored bytes, byte i at bits 8i+7..8i |
| outHiZ | output | 1 | Byte 0 bit 0: tristate clock outputs |
| spreadEn | output | 1 | Byte 0 bit 1: spread spectrum on |
| freqFromReg | output | 1 | Byte 0 bit 3: frequency from register, not pins |

## Verification
A byte counter that goes wrong shows up at the ports within one transfer. A write lands in the wrong slot of `cfgBytes` as soon as its acknowledge starts. A read-back after every write shows a wrong count byte or a shifted byte order at once. A bit counter that is off by one moves the acknowledge slot, so the master's sample in the ninth clock of the very next byte catches it. A read state machine that ignores a NACK keeps pulling SDA low in the clocks that follow, and those clocks are sampled directly.

// File: rtl/i2cCfgPkg.sv
package i2cCfgPkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned HIZ_BIT = 0;
  localparam int unsigned SPREAD_BIT = 1;
  localparam int unsigned FREQ_SRC_BIT = 3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic             rxShift;
    logic             wrEn;
    logic             txLoad;
    logic             txShift;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_RXACK, ST_TX, ST_TXACK, ST_TXWAIT
  } ctrlState_t;
endpackage

// File: rtl/i2cCfgSync.sv
module i2cCfgSync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  // idle bus level is high, so reset to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '1;
    else       stage <= {stage[STAGES-2:0], asyncIn};
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/i2cCfgData.sv
module i2cCfgData
  import i2cCfgPkg::*;
#(
  parameter int unsigned                 NUM_BYTES   = 7,
  parameter logic [NUM_BYTES*8-1:0]      RESET_VALUE = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdaBit,
  input  dpStrobe_t                strb,
  output logic [7:0]               rxByte,
  output logic                     txBit,
  output logic [NUM_BYTES*8-1:0]   cfgBytes
);
  logic [7:0] rxSr, txSr, txNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxSr <= '0;
    else if (strb.rxShift) rxSr <= {rxSr[6:0], sdaBit};
  end

  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  q <= RESET_VALUE[i*8 +: 8];
        else if (strb.wrEn && strb.idx == IDX_W'(i)) q <= rxSr;
      end
      assign cfgBytes[i*8 +: 8] = q;
    end
  endgenerate

  // index 0 is the count byte, 1..NUM_BYTES the stored bytes
  always_comb begin
    txNext = 8'hFF;
    if (strb.idx == '0) txNext = 8'(NUM_BYTES);
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (strb.idx == IDX_W'(i + 1)) txNext = cfgBytes[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txSr <= '1;
    else if (strb.txLoad)  txSr <= txNext;
    else if (strb.txShift) txSr <= {txSr[6:0], 1'b1};
  end

  assign rxByte = rxSr;
  assign txBit  = txSr[7];
endmodule

// File: rtl/i2cCfgCtrl.sv
module i2cCfgCtrl
  import i2cCfgPkg::*;
#(
  parameter logic [6:0]  ADDR7     = 7'h69,
  parameter int unsigned NUM_BYTES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaOe,
  output logic       startDet,
  output logic       stopDet
);
  localparam logic [IDX_W-1:0] WR_LIMIT = IDX_W'(NUM_BYTES + 2);
  localparam logic [IDX_W-1:0] RD_LIMIT = IDX_W'(NUM_BYTES + 1);
  localparam logic [7:0]       WR_ADDR  = {ADDR7, 1'b0};
  localparam logic [7:0]       RD_ADDR  = {ADDR7, 1'b1};

  ctrlState_t       state, stateN;
  logic [2:0]       bitCnt, bitCntN;
  logic             addrPhase, addrPhaseN, readMode, readModeN;
  logic [IDX_W-1:0] wrIdx, wrIdxN, rdIdx, rdIdxN;
  logic             sclD, sdaD, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    stateN     = state;
    bitCntN    = bitCnt;
    addrPhaseN = addrPhase;
    readModeN  = readMode;
    wrIdxN     = wrIdx;
    rdIdxN     = rdIdx;
    strb       = '0;
    if (startDet) begin
      stateN     = ST_RX;
      bitCntN    = '0;
      addrPhaseN = 1'b1;
      readModeN  = 1'b0;
      wrIdxN     = '0;
      rdIdxN     = '0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: if (sclRise) begin
          strb.rxShift = 1'b1;
          if (bitCnt == 3'd7) stateN = ST_RXEND;
          else                bitCntN = bitCnt + 3'd1;
        end
        ST_RXEND: if (sclFall) begin
          bitCntN = '0;
          if (addrPhase) begin
            addrPhaseN = 1'b0;
            if (rxByte == WR_ADDR) begin
              stateN    = ST_RXACK;
              readModeN = 1'b0;
            end else if (rxByte == RD_ADDR) begin
              stateN    = ST_RXACK;
              readModeN = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end else begin
            stateN = ST_RXACK;
            // first two bytes are command and count: not stored
            if (wrIdx >= IDX_W'(2) && wrIdx < WR_LIMIT) begin
              strb.wrEn = 1'b1;
              strb.idx  = wrIdx - IDX_W'(2);
            end
            if (wrIdx != WR_LIMIT) wrIdxN = wrIdx + IDX_W'(1);
          end
        end
        ST_RXACK: if (sclFall) begin
          bitCntN = '0;
          if (readMode) begin
            strb.txLoad = 1'b1;
            strb.idx    = rdIdx;
            if (rdIdx != RD_LIMIT) rdIdxN = rdIdx + IDX_W'(1);
            stateN = ST_TX;
          end else begin
            stateN = ST_RX;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            stateN = ST_TXACK;
          end else begin
            strb.txShift = 1'b1;
            bitCntN      = bitCnt + 3'd1;
          end
        end
        ST_TXACK: if (sclRise) begin
          stateN = sdaS ? ST_IDLE : ST_TXWAIT;
        end
        ST_TXWAIT: if (sclFall) begin
          bitCntN     = '0;
          strb.txLoad = 1'b1;
          strb.idx    = rdIdx;
          if (rdIdx != RD_LIMIT) rdIdxN = rdIdx + IDX_W'(1);
          stateN = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      addrPhase <= 1'b0;
      readMode  <= 1'b0;
      wrIdx     <= '0;
      rdIdx     <= '0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      addrPhase <= addrPhaseN;
      readMode  <= readModeN;
      wrIdx     <= wrIdxN;
      rdIdx     <= rdIdxN;
    end
  end

  assign sdaOe = (state == ST_RXACK) | ((state == ST_TX) & ~txBit);
endmodule

// File: rtl/i2cBlockCfg.sv
module i2cBlockCfg
  import i2cCfgPkg::*;
#(
  parameter logic [6:0]             ADDR7       = 7'h69,
  parameter int unsigned            NUM_BYTES   = 7,
  parameter int unsigned            SYNC_STAGES = 2,
  parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = 56'h5AC3817E24FF00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  output logic [NUM_BYTES*8-1:0] cfgBytes,
  output logic                   outHiZ,
  output logic                   spreadEn,
  output logic                   freqFromReg
);
  logic [1:0]       busS;
  logic             sclS, sdaS, txBit, startDet, stopDet, wrEnW;
  logic [7:0]       rxByte;
  logic [IDX_W-1:0] wrIdxW;
  dpStrobe_t        strb;

  i2cCfgSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({sclIn, sdaIn}), .syncOut(busS)
  );
  assign sclS = busS[1];
  assign sdaS = busS[0];

  i2cCfgCtrl #(.ADDR7(ADDR7), .NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .strb(strb), .sdaOe(sdaOe), .startDet(startDet),
    .stopDet(stopDet)
  );

  i2cCfgData #(.NUM_BYTES(NUM_BYTES), .RESET_VALUE(RESET_VALUE)) u_data (
    .clk(clk), .rstN(rstN), .sdaBit(sdaS), .strb(strb), .rxByte(rxByte),
    .txBit(txBit), .cfgBytes(cfgBytes)
  );

  assign wrEnW       = strb.wrEn;
  assign wrIdxW      = strb.idx;
  assign outHiZ      = cfgBytes[HIZ_BIT];
  assign spreadEn    = cfgBytes[SPREAD_BIT];
  assign freqFromReg = cfgBytes[FREQ_SRC_BIT];
endmodule

// File: rtl/i2cBlockCfgChk.sv
module i2cBlockCfgChk
  import i2cCfgPkg::*;
#(
  parameter int unsigned            NUM_BYTES   = 7,
  parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = '0
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclS,
  input logic                   sdaOe,
  input logic                   stopDet,
  input logic                   wrEn,
  input logic [IDX_W-1:0]       wrIdx,
  input logic [NUM_BYTES*8-1:0] cfgBytes
);
  // R1
  reset_default_chk: assert property (@(posedge clk)
    $rose(rstN) |-> cfgBytes == RESET_VALUE);

  // R4
  store_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgBytes) |-> $past(wrEn));

  // R6
  store_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrIdx < IDX_W'(NUM_BYTES));

  // R8
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R10
  drive_when_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);
endmodule

bind i2cBlockCfg i2cBlockCfgChk #(.NUM_BYTES(NUM_BYTES), .RESET_VALUE(RESET_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaOe(sdaOe), .stopDet(stopDet),
  .wrEn(wrEnW), .wrIdx(wrIdxW), .cfgBytes(cfgBytes)
);

// File: tb/i2cBlockCfg_tb.sv
`timescale 1ns/1ps
module i2cBlockCfg_tb;
  localparam int unsigned      NB   = 7;
  localparam logic [NB*8-1:0]  DEF  = 56'h5AC3817E24FF00;
  localparam int               HALF = 12;
  // each vector: {number of data bytes written, seed of data pattern}
  localparam logic [11:0] VEC [6] = '{
    {4'd7, 8'h11}, {4'd0, 8'h22}, {4'd3, 8'hA5},
    {4'd9, 8'h3C}, {4'd1, 8'h0B}, {4'd5, 8'hF0}
  };

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, outHiZ, spreadEn, freqFromReg;
  logic [NB*8-1:0] cfgBytes;
  logic sdaLine;
  logic [7:0] expMem [NB];
  int nVec = 0, nBad = 0;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2cBlockCfg #(.RESET_VALUE(DEF)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .cfgBytes(cfgBytes), .outHiZ(outHiZ), .spreadEn(spreadEn),
    .freqFromReg(freqFromReg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitXfer(input logic b, output logic r);
    sdaM = b;
    waitN(HALF);
    sclM = 1'b1;
    waitN(HALF / 2);
    r = sdaLine;
    waitN(HALF - HALF / 2);
    sclM = 1'b0;
    waitN(4);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b0; waitN(4);
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b1; waitN(HALF);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitXfer(v[i], r);
    bitXfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bitXfer(1'b1, r);
      v = {v[6:0], r};
    end
    bitXfer(~ackIt, r);
  endtask

  task automatic readCheck(input string tag);
    logic ack;
    logic [7:0] b;
    startC();
    sendByte(8'hD3, ack);
    chk(ack, "R2 read address ack", ack, 1);
    recvByte(1'b1, b);
    chk(b == 8'd7, "R7 count byte", b, 7);
    for (int k = 0; k < NB; k++) begin
      recvByte(k != NB - 1, b);
      chk(b == expMem[k], tag, b, expMem[k]);
    end
    stopC();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b, d;
    int n;
    for (int k = 0; k < NB; k++) expMem[k] = DEF[k*8 +: 8];
    waitN(6);
    chk(cfgBytes == DEF, "R1 reset contents", cfgBytes, DEF);
    rstN = 1'b1;
    waitN(4);
    chk(cfgBytes == DEF, "R1 defaults after reset", cfgBytes, DEF);
    // R9 decoded bits from byte 0 default 0
    chk({outHiZ, spreadEn, freqFromReg} == 3'b000, "R9 default decode",
        {outHiZ, spreadEn, freqFromReg}, 0);
    chk(sdaOe == 1'b0, "R8 idle released", sdaOe, 0);

    // vector table: write n bytes, then read all back
    for (int v = 0; v < 6; v++) begin
      n = int'(VEC[v][11:8]);
      startC();
      sendByte(8'hD2, ack);
      chk(ack, "R2 write address ack", ack, 1);
      sendByte(8'h5E, ack);
      chk(ack, "R3 command ack", ack, 1);
      sendByte(8'h07, ack);
      chk(ack, "R3 count ack", ack, 1);
      for (int k = 0; k < n; k++) begin
        d = VEC[v][7:0] + 8'(k * 37);
        sendByte(d, ack);
        chk(ack, (k < NB) ? "R4 data ack" : "R6 extra byte ack", ack, 1);
        if (k < NB) expMem[k] = d;
      end
      stopC();
      chk(cfgBytes[7:0] == expMem[0], "R5 byte 0 after stop", cfgBytes[7:0], expMem[0]);
      chk({outHiZ, spreadEn, freqFromReg} == {expMem[0][0], expMem[0][1], expMem[0][3]},
          "R9 decode", {outHiZ, spreadEn, freqFromReg}, {expMem[0][0], expMem[0][1], expMem[0][3]});
      readCheck((n < NB) ? "R5 partial write readback" : "R4 readback");
    end

    // unknown address: no ack, nothing stored
    startC();
    sendByte(8'hA4, ack);
    chk(!ack, "R2 foreign address nack", ack, 0);
    sendByte(8'h00, ack);
    chk(!ack, "R2 ignored after foreign address", ack, 0);
    sendByte(8'h99, ack);
    chk(!ack, "R2 ignored after foreign address", ack, 0);
    stopC();
    readCheck("R2 contents unchanged");

    // master NACK ends the read; following bits come back released
    startC();
    sendByte(8'hD3, ack);
    chk(ack, "R2 read address ack", ack, 1);
    recvByte(1'b1, b);
    chk(b == 8'd7, "R7 count byte", b, 7);
    recvByte(1'b0, b);
    chk(b == expMem[0], "R7 byte 0", b, expMem[0]);
    recvByte(1'b1, b);
    chk(b == 8'hFF, "R8 released after nack", b, 8'hFF);
    chk(sdaOe == 1'b0, "R8 no drive after nack", sdaOe, 0);
    stopC();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule